// File: doc/BRIEF.md
# Sprite Attribute Table Copy Engine

This block moves one fixed-size run of bytes from system memory into the sprite attribute table, so that software can refresh every sprite entry with a single register write. A pulse on the start input, with a page number beside it, sets the source base to that page times 0x100. The engine then reads the bytes one at a time through a simple request/valid read port and writes each returned byte to the attribute table, starting at address 0xFE00.

Only one read is in flight at a time. The request stays high, with its address held, until the memory answers with a valid strobe. The byte that arrives is written to the table in the following cycle. A busy flag covers the whole transfer. Arbitration against the processor belongs to the surrounding fabric.

Top module: `sprite_dma`

## Requirements
- R1: After reset, busy_o, rd_req_o and wr_en_o are all low.
- R2: A start pulse while idle raises busy_o in the next cycle. The first read request has the address page_i * 0x100.
- R3: Read n uses the address base + n, for n ascending from 0. While a request waits for rd_valid_i, rd_req_o stays high and rd_addr_o does not change.
- R4: Write n goes to wr_addr_o = 0xFE00 + n and carries the rd_data_i byte returned for read n.
- R5: Each start produces exactly 160 writes. busy_o is low in the cycle after the 160th write.
- R6: A start pulse while busy_o is high is ignored. The running transfer keeps its source page and its byte count.
- R7: Every write is preceded by exactly one cycle in which rd_req_o and rd_valid_i are both high. Write pulses never occur in two consecutive cycles.
- R8: A rd_valid_i strobe while no request is pending causes no write and does not start a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle trigger |
| page_i | input | 8 | Source page, sampled with start_i |
| rd_addr_o | output | 16 | Read address |
| rd_req_o | output | 1 | Read request, held until valid |
| rd_valid_i | input | 1 | Read data valid strobe |
| rd_data_i | input | 8 | Read data |
| wr_en_o | output | 1 | Attribute table write strobe |
| wr_addr_o | output | 16 | Attribute table write address |
| wr_data_o | output | 8 | Attribute table write data |
| busy_o | output | 1 | Transfer in progress |

## Verification
A corrupted byte index shows up at the ports at once. The next read address breaks the base + n sequence, and the next write lands on the wrong table slot, so every read and write is compared with its expected value as it happens. A state machine stuck in the write state, or one that skips the wait for valid, shows within one cycle as a write with no matching valid or as two writes back to back. A wrong terminal count shows when the transfer ends, as a write total other than 160 or as busy staying high after the last write. Each transfer is run against memory latencies from zero to five cycles, so that the wait behaviour is exercised.

// File: rtl/sprite_dma.sv
module sprite_dma #(
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8,
  parameter int DST_W = 16,
  parameter int NBYTES = 160,
  parameter logic [DST_W-1:0] DST_BASE = 16'hFE00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [PAGE_W+7:0] rd_addr_o,
  output logic              rd_req_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [DST_W-1:0]  wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              busy_o
);
  localparam int ADDR_W = PAGE_W + 8;
  localparam int CNT_W = $clog2(NBYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  typedef enum logic [1:0] {IDLE, REQ, WR} state_t;
  state_t state;
  logic [PAGE_W-1:0] page_q;
  logic [CNT_W-1:0] idx;
  logic [DATA_W-1:0] data_q;

  assign busy_o = state != IDLE;
  assign rd_req_o = state == REQ;
  assign wr_en_o = state == WR;
  assign rd_addr_o = {page_q, 8'h00} + ADDR_W'(idx);
  assign wr_addr_o = DST_BASE + DST_W'(idx);
  assign wr_data_o = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE;
      page_q <= '0;
      idx <= '0;
      data_q <= '0;
    end else begin
      unique case (state)
        IDLE: if (start_i) begin
          page_q <= page_i;
          idx <= '0;
          state <= REQ;
        end
        REQ: if (rd_valid_i) begin
          data_q <= rd_data_i;
          state <= WR;
        end
        WR: begin
          if (idx == LAST) state <= IDLE;
          else begin
            idx <= idx + 1'b1;
            state <= REQ;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));
  // R4
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> busy_o && wr_addr_o >= DST_BASE && wr_addr_o <= DST_BASE + DST_W'(NBYTES - 1));
  // R7
  wr_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(rd_req_o && rd_valid_i));
  // R7
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);
  // R8
  idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i |=> !busy_o && !wr_en_o);
endmodule

// File: tb/sim_sprite_dma.sv
module sim_sprite_dma;
  logic clk = 0, rst_n = 0, start_i = 0;
  logic [7:0] page_i = 0;
  logic [15:0] rd_addr_o, wr_addr_o;
  logic rd_req_o, wr_en_o, busy_o;
  logic mem_v = 0, stray_v = 0;
  logic [7:0] mem_d = 0, wr_data_o;
  wire rd_valid_i = mem_v | stray_v;

  always #4 clk = ~clk;

  sprite_dma u0 (.clk(clk), .rst_n(rst_n), .start_i(start_i), .page_i(page_i),
    .rd_addr_o(rd_addr_o), .rd_req_o(rd_req_o), .rd_valid_i(rd_valid_i),
    .rd_data_i(mem_d), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .busy_o(busy_o));

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  int lat = 0, wcnt = 0;
  always @(posedge clk) begin
    if (mem_v) begin mem_v <= 0; wcnt <= 0; end
    else if (rd_req_o) begin
      if (wcnt >= lat) begin mem_v <= 1; mem_d <= pat(rd_addr_o); end
      else wcnt <= wcnt + 1;
    end
  end

  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] cur_src = 0, prev_addr = 0;
  int widx = 0, ridx = 0, aerr = 0, werr = 0, verr = 0, berr = 0;
  bit pend = 0, busy_next = 0, waiting = 0;

  always @(negedge clk) begin
    if (busy_next) begin if (busy_o) berr++; busy_next = 0; end
    if (wr_en_o) begin
      if (!pend) verr++;
      pend = 0;
      if (wr_addr_o !== 16'hFE00 + 16'(widx) || wr_data_o !== pat(cur_src + 16'(widx))) werr++;
      widx++;
      if (widx == 160) busy_next = 1;
    end
    if (rd_req_o && waiting && rd_addr_o !== prev_addr) aerr++;
    if (rd_req_o && rd_valid_i) begin
      if (pend) verr++;
      if (rd_addr_o !== cur_src + 16'(ridx)) aerr++;
      ridx++; pend = 1; waiting = 0;
    end else begin
      waiting = rd_req_o; prev_addr = rd_addr_o;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic run_xfer(input logic [7:0] pg, input int l, input bit poke);
    lat = l; cur_src = {pg, 8'h00};
    widx = 0; ridx = 0; aerr = 0; werr = 0; verr = 0; berr = 0;
    start_i = 1; page_i = pg;
    chk("R2 busy before edge", busy_o, 0);
    tick();
    start_i = 0;
    chk("R2 busy after start", busy_o, 1);
    chk("R2 first read address", rd_addr_o, {pg, 8'h00});
    if (poke) begin
      repeat (20) tick();
      start_i = 1; page_i = pg ^ 8'h55;
      tick();
      start_i = 0;
    end
    for (int i = 0; i < 3000 && busy_o; i++) tick();
    tick();
    chk("R3 read address sequence errors", aerr, 0);
    chk("R4 write address/data errors", werr, 0);
    chk("R5 write count", widx, 160);
    chk("R5 busy low after last write", berr, 0);
    chk("R7 write without valid", verr, 0);
    if (poke) chk("R6 restart ignored, reads", ridx, 160);
  endtask

  localparam logic [11:0] VEC [5] = '{
    {8'h00, 4'd0}, {8'hC1, 4'd3}, {8'hFF, 4'd1}, {8'h80, 4'd5}, {8'h3A, 4'd2}};

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R1 busy", busy_o, 0);
    chk("R1 rd_req", rd_req_o, 0);
    chk("R1 wr_en", wr_en_o, 0);
    rst_n = 1;
    tick();
    foreach (VEC[k]) run_xfer(VEC[k][11:4], int'(VEC[k][3:0]), 0);
    run_xfer(8'h12, 2, 1);
    repeat (4) tick();
    chk("R6 no extra writes after ignored start", widx, 160);
    chk("R6 idle after ignored start", busy_o, 0);
    stray_v = 1; tick(); tick(); stray_v = 0;
    repeat (4) tick();
    chk("R8 stray valid writes", widx, 160);
    chk("R8 stray valid busy", busy_o, 0);
    chk("R8 stray valid request", rd_req_o, 0);
    run_xfer(8'h44, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule